// File: doc/BRIEF.md
# Remote DMA Port Engine

This block moves data between a host data port and a local packet memory. It keeps a current address and a remaining byte count. Each accepted data-port access makes one memory access of 1, 2 or 4 bytes at the current address, then moves the address on by that step and lowers the count. Memory is byte addressed and little-endian. When the address reaches the ring stop page it is reloaded with the ring start page. When the count runs out, a completion status bit is set and held until the host clears it.

The host programs the engine through a byte-wide register interface. The address and count are each written as separate low and high bytes, and both can be read back at any time, including during a transfer. A command register can also raise completion at once for a transfer of zero length. Data-port accesses use a valid/ready handshake. Read data returns on a separate valid/ready response channel. A response that is not taken holds the port closed, so the engine never has more than one read outstanding. Only addresses in a low area or in a packet memory window reach memory. Other reads return all ones and other writes are dropped.

Top module: `rdma_port_engine`

## Requirements
- R1: Register selects 0/1 write the low/high byte of the 16-bit current address, and selects 2/3 do the same for the 16-bit remaining count. Reading the same selects returns the current values. Selects 4 and 5 hold the ring start and stop pages (address = page*256), select 6 is data configuration, select 7 is command and select 8 is status.
- R2: A port access of size code 2 (32-bit) always steps 4 bytes. Size codes 0 (8-bit) and 1 (16-bit) step 2 bytes when data configuration bit 0 is 1, and 1 byte otherwise.
- R3: Multi-byte accesses use the address with bit 0 forced to 0. Data is little-endian: the byte at the lowest address sits in bits 7:0 of the port data. Read data is zero-extended above the step width.
- R4: After an access the address increases by the step (the un-forced address is used). If the result equals stop page*256, the address becomes start page*256.
- R5: If the remaining count is less than or equal to the step, it becomes 0 and status bit 6 (completion) is set. Otherwise the count drops by the step. Without an access or a register write, the count does not change.
- R6: A port write while the count is 0 is ignored: no memory write, and address, count and completion stay unchanged.
- R7: A command write (select 7) with bit 0 clear and bit 3 or bit 4 set, made while the count is 0, sets completion at once. Any other command write leaves completion unchanged. The command reads back as written.
- R8: Only effective addresses below 32, or in [0x4000, 0x8000), access memory. Outside these ranges reads return all ones in the step width and writes are dropped, but the address and count still advance.
- R9: Writing status (select 8) with bit 6 set clears completion. The done_flag output equals the completion bit.
- R10: port_ready is low while a read is in flight, while a response is held, and during a register write. resp_data stays stable while resp_valid is high and resp_ready is low.
- R11: After reset the address, the count and completion are 0, and port_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Readback of the selected register |
| port_valid | input | 1 | Data-port access request |
| port_ready | output | 1 | Engine can accept an access |
| port_write | input | 1 | 1 = write access, 0 = read access |
| port_size | input | 2 | Access width code: 0 8-bit, 1 16-bit, 2 32-bit |
| port_wdata | input | 32 | Write data, little-endian |
| resp_valid | output | 1 | Read response available |
| resp_ready | input | 1 | Host takes the response |
| resp_data | output | 32 | Read response data |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | 16 | Memory byte address |
| mem_be | output | 4 | Byte enables, lane 0 at mem_addr |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_req |
| done_flag | output | 1 | Completion status |

## Verification
A wrong step, wrap or count decrement shows up on the first readback of the address or count select after that access, and on the lanes of the next read response. A completion bit set early or late shows on done_flag in the cycle after the access or command that decides it. A lost held response, or an access accepted while a response is pending, shows as unstable resp_data or a port_ready that stays high while a response is held, within one cycle.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } port_size_e;

  typedef enum logic [3:0] {
    SEL_ADDR_LO    = 4'd0,
    SEL_ADDR_HI    = 4'd1,
    SEL_CNT_LO     = 4'd2,
    SEL_CNT_HI     = 4'd3,
    SEL_RING_FIRST = 4'd4,
    SEL_RING_LAST  = 4'd5,
    SEL_DATACFG    = 4'd6,
    SEL_CMD        = 4'd7,
    SEL_STATUS     = 4'd8
  } reg_sel_e;

  localparam int CMD_HALT_BIT  = 0;
  localparam int CMD_RD_BIT    = 3;
  localparam int CMD_WR_BIT    = 4;
  localparam int DONE_BIT      = 6;
  localparam int CFG_WORD_BIT  = 0;
endpackage

// File: rtl/rdma_step.sv
module rdma_step
  import rdma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int LOW_LIMIT = 32,
  parameter int WIN_LO    = 'h4000,
  parameter int WIN_HI    = 'h8000,
  localparam int PAGE_W   = ADDR_W - 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  port_size_e        size_i,
  input  logic              word_mode_i,
  input  logic [PAGE_W-1:0] ring_first_i,
  input  logic [PAGE_W-1:0] ring_last_i,
  output logic [2:0]        nbytes_o,
  output logic [3:0]        be_o,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic              in_win_o,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic [CNT_W-1:0]  next_cnt_o,
  output logic              exhaust_o
);
  logic [ADDR_W-1:0] sum_addr;
  logic [ADDR_W-1:0] stop_addr;
  logic [ADDR_W-1:0] first_addr;
  logic              low_hit;
  logic              win_hit;

  always_comb begin
    if (size_i == SZ_WORD)  nbytes_o = 3'd4;
    else if (word_mode_i)   nbytes_o = 3'd2;
    else                    nbytes_o = 3'd1;
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign be_o[i] = (3'(i) < nbytes_o);
  end

  assign eff_addr_o = (nbytes_o == 3'd1) ? addr_i : {addr_i[ADDR_W-1:1], 1'b0};

  if (LOW_LIMIT > 0) begin : g_low
    assign low_hit = (eff_addr_o < ADDR_W'(LOW_LIMIT));
  end else begin : g_nolow
    assign low_hit = 1'b0;
  end

  assign win_hit  = (eff_addr_o >= ADDR_W'(WIN_LO)) && (eff_addr_o < ADDR_W'(WIN_HI));
  assign in_win_o = low_hit || win_hit;

  assign stop_addr  = {ring_last_i, 8'h00};
  assign first_addr = {ring_first_i, 8'h00};
  assign sum_addr   = addr_i + ADDR_W'(nbytes_o);
  assign next_addr_o = (sum_addr == stop_addr) ? first_addr : sum_addr;

  assign exhaust_o  = (cnt_i <= CNT_W'(nbytes_o));
  assign next_cnt_o = exhaust_o ? '0 : cnt_i - CNT_W'(nbytes_o);
endmodule

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 16,
  localparam int PAGE_W = ADDR_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              upd_en,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic [CNT_W-1:0]  upd_cnt,
  input  logic              upd_done,
  output logic [ADDR_W-1:0] addr_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [PAGE_W-1:0] ring_first_q,
  output logic [PAGE_W-1:0] ring_last_q,
  output logic              word_mode,
  output logic              done_q
);
  logic [7:0] cfg_q;
  logic [7:0] cmd_q;
  logic       zero_start;

  assign word_mode  = cfg_q[CFG_WORD_BIT];
  assign zero_start = !reg_wdata[CMD_HALT_BIT]
                    && (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT])
                    && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q       <= '0;
      cnt_q        <= '0;
      ring_first_q <= '0;
      ring_last_q  <= '0;
      cfg_q        <= '0;
      cmd_q        <= '0;
      done_q       <= 1'b0;
    end else if (reg_we) begin
      case (reg_sel_e'(reg_sel))
        SEL_ADDR_LO:    addr_q[7:0]        <= reg_wdata;
        SEL_ADDR_HI:    addr_q[ADDR_W-1:8] <= reg_wdata[PAGE_W-1:0];
        SEL_CNT_LO:     cnt_q[7:0]         <= reg_wdata;
        SEL_CNT_HI:     cnt_q[CNT_W-1:8]   <= reg_wdata[CNT_W-9:0];
        SEL_RING_FIRST: ring_first_q       <= reg_wdata[PAGE_W-1:0];
        SEL_RING_LAST:  ring_last_q        <= reg_wdata[PAGE_W-1:0];
        SEL_DATACFG:    cfg_q              <= reg_wdata;
        SEL_CMD: begin
          cmd_q <= reg_wdata;
          if (zero_start) done_q <= 1'b1;
        end
        SEL_STATUS: begin
          if (reg_wdata[DONE_BIT]) done_q <= 1'b0;
        end
        default: ;
      endcase
    end else if (upd_en) begin
      addr_q <= upd_addr;
      cnt_q  <= upd_cnt;
      if (upd_done) done_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_sel_e'(reg_sel))
      SEL_ADDR_LO:    reg_rdata = addr_q[7:0];
      SEL_ADDR_HI:    reg_rdata = 8'(addr_q[ADDR_W-1:8]);
      SEL_CNT_LO:     reg_rdata = cnt_q[7:0];
      SEL_CNT_HI:     reg_rdata = 8'(cnt_q[CNT_W-1:8]);
      SEL_RING_FIRST: reg_rdata = 8'(ring_first_q);
      SEL_RING_LAST:  reg_rdata = 8'(ring_last_q);
      SEL_DATACFG:    reg_rdata = cfg_q;
      SEL_CMD:        reg_rdata = cmd_q;
      SEL_STATUS:     reg_rdata = 8'(done_q) << DONE_BIT;
      default:        reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rdma_resp.sv
module rdma_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              issue_win,
  input  logic [2:0]        issue_nbytes,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              resp_ready,
  output logic              pend_q,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);
  logic              win_q;
  logic [2:0]        nb_q;
  logic [DATA_W-1:0] lane_mask;

  always_comb begin
    case (nb_q)
      3'd4:    lane_mask = '1;
      3'd2:    lane_mask = DATA_W'(16'hFFFF);
      default: lane_mask = DATA_W'(8'hFF);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      win_q      <= 1'b0;
      nb_q       <= 3'd1;
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      if (issue) begin
        pend_q <= 1'b1;
        win_q  <= issue_win;
        nb_q   <= issue_nbytes;
      end else if (pend_q) begin
        pend_q     <= 1'b0;
        resp_valid <= 1'b1;
        resp_data  <= win_q ? (mem_rdata & lane_mask) : lane_mask;
      end else if (resp_valid && resp_ready) begin
        resp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int LOW_LIMIT = 32,
  parameter int WIN_LO    = 'h4000,
  parameter int WIN_HI    = 'h8000,
  localparam int PAGE_W   = ADDR_W - 8,
  localparam int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              port_valid,
  output logic              port_ready,
  input  logic              port_write,
  input  logic [1:0]        port_size,
  input  logic [DATA_W-1:0] port_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done_flag
);
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;
  logic [PAGE_W-1:0] ring_first;
  logic [PAGE_W-1:0] ring_last;
  logic              word_mode;
  logic [2:0]        acc_bytes;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] next_addr;
  logic [CNT_W-1:0]  next_cnt;
  logic              in_win;
  logic              exhaust;
  logic              pend_q;
  logic              port_fire;
  logic              wr_ignored;
  logic              do_access;

  assign port_ready = !pend_q && !resp_valid && !reg_we;
  assign port_fire  = port_valid && port_ready;
  assign wr_ignored = port_write && (cur_cnt == '0);
  assign do_access  = port_fire && !wr_ignored;

  assign mem_req   = do_access && in_win;
  assign mem_we    = port_write;
  assign mem_addr  = eff_addr;
  assign mem_wdata = port_wdata;

  rdma_step #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOW_LIMIT(LOW_LIMIT),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_step (
    .addr_i       (cur_addr),
    .cnt_i        (cur_cnt),
    .size_i       (port_size_e'(port_size)),
    .word_mode_i  (word_mode),
    .ring_first_i (ring_first),
    .ring_last_i  (ring_last),
    .nbytes_o     (acc_bytes),
    .be_o         (mem_be),
    .eff_addr_o   (eff_addr),
    .in_win_o     (in_win),
    .next_addr_o  (next_addr),
    .next_cnt_o   (next_cnt),
    .exhaust_o    (exhaust)
  );

  rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_sel      (reg_sel),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .upd_en       (do_access),
    .upd_addr     (next_addr),
    .upd_cnt      (next_cnt),
    .upd_done     (exhaust),
    .addr_q       (cur_addr),
    .cnt_q        (cur_cnt),
    .ring_first_q (ring_first),
    .ring_last_q  (ring_last),
    .word_mode    (word_mode),
    .done_q       (done_flag)
  );

  rdma_resp #(.DATA_W(DATA_W)) u_resp (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue        (do_access && !port_write),
    .issue_win    (in_win),
    .issue_nbytes (acc_bytes),
    .mem_rdata    (mem_rdata),
    .resp_ready   (resp_ready),
    .pend_q       (pend_q),
    .resp_valid   (resp_valid),
    .resp_data    (resp_data)
  );
endmodule

// File: rtl/rdma_port_engine_chk.sv
module rdma_port_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              port_valid,
  input logic              port_ready,
  input logic              port_write,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [31:0]       resp_data,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic              done_flag,
  input logic [CNT_W-1:0]  cur_cnt,
  input logic [2:0]        acc_bytes
);
  logic fire;
  assign fire = port_valid && port_ready;

  // R5: the access that uses up the count raises completion
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(port_write && cur_cnt == '0) && cur_cnt <= CNT_W'(acc_bytes)) |=> done_flag);

  // R5: count is stable without an access or a register write
  a_r5_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !reg_we) |=> $stable(cur_cnt));

  // R6: a write with an empty count never reaches memory
  a_r6_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && port_write && cur_cnt == '0) |-> !mem_req);

  // R3: multi-byte memory accesses are even
  a_r3_even_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_be != 4'b0001) |-> !mem_addr[0]);

  // R10: a held response closes the port
  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !port_ready);

  // R10: a response not taken stays put
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));
endmodule

bind rdma_port_engine rdma_port_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_we     (reg_we),
  .port_valid (port_valid),
  .port_ready (port_ready),
  .port_write (port_write),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_data  (resp_data),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .done_flag  (done_flag),
  .cur_cnt    (cur_cnt),
  .acc_bytes  (acc_bytes)
);

// File: tb/rdma_port_engine_test.sv
module rdma_port_engine_test;
  localparam logic [1:0] OP_RW = 2'd0, OP_RR = 2'd1, OP_PW = 2'd2, OP_PR = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  sel;
    logic [1:0]  size;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t VECS [NV] = '{
    '{OP_RW, 4'd6, 2'd0, 32'h00, 32'h0, 4'd2},          // R2 byte mode
    '{OP_RW, 4'd4, 2'd0, 32'h40, 32'h0, 4'd4},          // R4 ring start page
    '{OP_RW, 4'd5, 2'd0, 32'h41, 32'h0, 4'd4},          // R4 ring stop page
    '{OP_RR, 4'd4, 2'd0, 32'h0,  32'h40, 4'd1},         // R1
    '{OP_RW, 4'd0, 2'd0, 32'hFE, 32'h0, 4'd1},          // R1
    '{OP_RW, 4'd1, 2'd0, 32'h40, 32'h0, 4'd1},          // R1
    '{OP_RW, 4'd2, 2'd0, 32'h05, 32'h0, 4'd1},          // R1
    '{OP_RW, 4'd3, 2'd0, 32'h00, 32'h0, 4'd1},          // R1
    '{OP_RR, 4'd0, 2'd0, 32'h0,  32'hFE, 4'd1},         // R1
    '{OP_RR, 4'd1, 2'd0, 32'h0,  32'h40, 4'd1},         // R1
    '{OP_PW, 4'd0, 2'd0, 32'hA1, 32'h0, 4'd2},          // R2 byte at 40FE
    '{OP_RR, 4'd2, 2'd0, 32'h0,  32'h04, 4'd5},         // R5
    '{OP_PW, 4'd0, 2'd1, 32'hA2, 32'h0, 4'd2},          // R2 16-bit code, 1 byte
    '{OP_RR, 4'd0, 2'd0, 32'h0,  32'h00, 4'd4},         // R4 wrapped
    '{OP_RR, 4'd1, 2'd0, 32'h0,  32'h40, 4'd4},         // R4
    '{OP_RR, 4'd2, 2'd0, 32'h0,  32'h03, 4'd2},         // R2
    '{OP_PW, 4'd0, 2'd2, 32'h44332211, 32'h0, 4'd2},    // R2 32-bit
    '{OP_RR, 4'd8, 2'd0, 32'h0,  32'h40, 4'd5},         // R5 done
    '{OP_RR, 4'd2, 2'd0, 32'h0,  32'h00, 4'd5},         // R5
    '{OP_RR, 4'd0, 2'd0, 32'h0,  32'h04, 4'd4},         // R4
    '{OP_PW, 4'd0, 2'd0, 32'h99, 32'h0, 4'd6},          // R6 ignored
    '{OP_RR, 4'd0, 2'd0, 32'h0,  32'h04, 4'd6},         // R6
    '{OP_RR, 4'd2, 2'd0, 32'h0,  32'h00, 4'd6},         // R6
    '{OP_RW, 4'd8, 2'd0, 32'h40, 32'h0, 4'd9},          // R9 clear
    '{OP_RR, 4'd8, 2'd0, 32'h0,  32'h00, 4'd9},         // R9
    '{OP_RW, 4'd0, 2'd0, 32'h00, 32'h0, 4'd1},          // R1
    '{OP_RW, 4'd2, 2'd0, 32'h10, 32'h0, 4'd1},          // R1
    '{OP_RW, 4'd6, 2'd0, 32'h01, 32'h0, 4'd2},          // R2 word mode
    '{OP_PR, 4'd0, 2'd0, 32'h0,  32'h2211, 4'd3},       // R3 little-endian
    '{OP_PR, 4'd0, 2'd1, 32'h0,  32'h4433, 4'd3},       // R3
    '{OP_RR, 4'd0, 2'd0, 32'h0,  32'h04, 4'd4},         // R4
    '{OP_RR, 4'd2, 2'd0, 32'h0,  32'h0C, 4'd5},         // R5
    '{OP_RW, 4'd0, 2'd0, 32'hFF, 32'h0, 4'd3},          // R3 odd address
    '{OP_PR, 4'd0, 2'd1, 32'h0,  32'hA2A1, 4'd3},       // R3 forced even
    '{OP_RR, 4'd1, 2'd0, 32'h0,  32'h41, 4'd4},         // R4 no wrap at 4101
    '{OP_RR, 4'd0, 2'd0, 32'h0,  32'h01, 4'd4},         // R4
    '{OP_RR, 4'd2, 2'd0, 32'h0,  32'h0A, 4'd5},         // R5
    '{OP_RW, 4'd1, 2'd0, 32'h20, 32'h0, 4'd8},          // R8
    '{OP_RW, 4'd0, 2'd0, 32'h00, 32'h0, 4'd8},          // R8
    '{OP_PR, 4'd0, 2'd2, 32'h0,  32'hFFFFFFFF, 4'd8},   // R8 outside
    '{OP_PR, 4'd0, 2'd1, 32'h0,  32'h0000FFFF, 4'd8},   // R8 outside 16
    '{OP_RR, 4'd0, 2'd0, 32'h0,  32'h06, 4'd8},         // R8 still advances
    '{OP_RR, 4'd2, 2'd0, 32'h0,  32'h04, 4'd5},         // R5
    '{OP_RW, 4'd6, 2'd0, 32'h00, 32'h0, 4'd2},          // R2
    '{OP_RW, 4'd1, 2'd0, 32'h00, 32'h0, 4'd8},          // R8
    '{OP_RW, 4'd0, 2'd0, 32'h1F, 32'h0, 4'd8},          // R8
    '{OP_PW, 4'd0, 2'd0, 32'h5A, 32'h0, 4'd8},          // R8 low area
    '{OP_RW, 4'd0, 2'd0, 32'h1F, 32'h0, 4'd8},          // R8
    '{OP_PR, 4'd0, 2'd0, 32'h0,  32'h5A, 4'd8},         // R8
    '{OP_PR, 4'd0, 2'd0, 32'h0,  32'hFF, 4'd8},         // R8 address 32
    '{OP_PR, 4'd0, 2'd0, 32'h0,  32'hFF, 4'd5},         // R5 last byte
    '{OP_RR, 4'd8, 2'd0, 32'h0,  32'h40, 4'd5},         // R5
    '{OP_RW, 4'd8, 2'd0, 32'h40, 32'h0, 4'd9},          // R9
    '{OP_RW, 4'd7, 2'd0, 32'h0A, 32'h0, 4'd7},          // R7 zero-length
    '{OP_RR, 4'd8, 2'd0, 32'h0,  32'h40, 4'd7},         // R7
    '{OP_RR, 4'd7, 2'd0, 32'h0,  32'h0A, 4'd7},         // R7
    '{OP_RW, 4'd8, 2'd0, 32'h40, 32'h0, 4'd9},          // R9
    '{OP_RW, 4'd7, 2'd0, 32'h09, 32'h0, 4'd7},          // R7 halted
    '{OP_RR, 4'd8, 2'd0, 32'h0,  32'h00, 4'd7},         // R7
    '{OP_RW, 4'd7, 2'd0, 32'h22, 32'h0, 4'd7},          // R7 no transfer
    '{OP_RR, 4'd8, 2'd0, 32'h0,  32'h00, 4'd7},         // R7
    '{OP_RW, 4'd2, 2'd0, 32'h01, 32'h0, 4'd7},          // R7
    '{OP_RW, 4'd7, 2'd0, 32'h12, 32'h0, 4'd7},          // R7 nonzero count
    '{OP_RR, 4'd8, 2'd0, 32'h0,  32'h00, 4'd7}          // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        port_valid = 1'b0;
  logic        port_ready;
  logic        port_write = 1'b0;
  logic [1:0]  port_size = '0;
  logic [31:0] port_wdata = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b0;
  logic [31:0] resp_data;
  logic        mem_req;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        done_flag;

  int applied = 0;
  int fails = 0;
  int wr_count = 0;
  int cycles = 0;
  logic [7:0] bmem [512];

  always #10 clk = ~clk;

  rdma_port_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_valid(port_valid),
    .port_ready(port_ready), .port_write(port_write), .port_size(port_size),
    .port_wdata(port_wdata), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done_flag(done_flag)
  );

  function automatic int idx(input logic [15:0] a);
    return int'({a[14], a[7:0]});
  endfunction

  always @(posedge clk) begin
    if (mem_req && mem_we) begin
      wr_count <= wr_count + 1;
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) bmem[idx(mem_addr + 16'(i))] <= mem_wdata[8*i +: 8];
    end
    if (mem_req && !mem_we)
      mem_rdata <= {bmem[idx(mem_addr + 16'd3)], bmem[idx(mem_addr + 16'd2)],
                    bmem[idx(mem_addr + 16'd1)], bmem[idx(mem_addr)]};
  end

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h, expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  task automatic port_op(input logic wr, input logic [1:0] sz, input logic [31:0] wd,
                         output logic [31:0] rd);
    @(negedge clk);
    port_valid = 1'b1; port_write = wr; port_size = sz; port_wdata = wd;
    #1;
    while (!port_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    port_valid = 1'b0;
    rd = '0;
    if (!wr) begin
      #1;
      while (!resp_valid) begin @(negedge clk); #1; end
      rd = resp_data;
      resp_ready = 1'b1;
      @(negedge clk);
      resp_ready = 1'b0;
    end
  endtask

  initial begin
    while (cycles < 200000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

  initial begin
    logic [7:0]  rb;
    logic [31:0] rdw;
    int          w0;
    vec_t        v;
    for (int i = 0; i < 512; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R11 reset state
    chk(11, {31'd0, port_ready}, 32'd1);
    chk(11, {31'd0, done_flag}, 32'd0);
    reg_read(4'd0, rb); chk(11, {24'd0, rb}, 32'h00);
    reg_read(4'd2, rb); chk(11, {24'd0, rb}, 32'h00);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      case (v.op)
        OP_RW: reg_write(v.sel, v.data[7:0]);
        OP_RR: begin reg_read(v.sel, rb); chk(int'(v.req), {24'd0, rb}, v.exp); end
        OP_PW: port_op(1'b1, v.size, v.data, rdw);
        default: begin port_op(1'b0, v.size, 32'h0, rdw); chk(int'(v.req), rdw, v.exp); end
      endcase
    end

    // R9 done_flag output follows completion
    reg_write(4'd2, 8'h00);
    reg_write(4'd7, 8'h0A);
    @(negedge clk); #1 chk(9, {31'd0, done_flag}, 32'd1);
    reg_write(4'd8, 8'h40);
    @(negedge clk); #1 chk(9, {31'd0, done_flag}, 32'd0);

    // R8 write outside the window is dropped but advances the address
    reg_write(4'd1, 8'h20); reg_write(4'd0, 8'h00); reg_write(4'd2, 8'h04);
    w0 = wr_count;
    port_op(1'b1, 2'd0, 32'h77, rdw);
    @(negedge clk);
    chk(8, 32'(wr_count), 32'(w0));
    reg_read(4'd0, rb); chk(8, {24'd0, rb}, 32'h01);

    // R10 back-pressure on a held response (byte mode, memory 0x4000 = 0x11)
    reg_write(4'd1, 8'h40); reg_write(4'd0, 8'h00); reg_write(4'd2, 8'h04);
    @(negedge clk);
    port_valid = 1'b1; port_write = 1'b0; port_size = 2'd0;
    #1 chk(10, {31'd0, port_ready}, 32'd1);
    @(negedge clk);
    port_valid = 1'b0;
    #1 chk(10, {31'd0, port_ready}, 32'd0);
    @(negedge clk);
    #1 chk(10, {31'd0, resp_valid}, 32'd1);
    chk(10, resp_data, 32'h11);
    @(negedge clk);
    #1 chk(10, {31'd0, port_ready}, 32'd0);
    chk(10, resp_data, 32'h11);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    #1 chk(10, {31'd0, resp_valid}, 32'd0);
    chk(10, {31'd0, port_ready}, 32'd1);

    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end
endmodule